// File: doc/BRIEF.md
# Four-Port Memory Arbiter with Burst-Mode Reload

This block shares one SDRAM controller command port among four cache-side requesters. A requester signals a miss and supplies a read or write request, an address, byte enables, write data and a mode word that holds the burst length it wants. When the arbiter is idle it picks one of the requesters that is missing and keeps that grant until the requester reports that its transaction is complete.

The controller holds one mode register, so only one burst length is in force at a time. The arbiter keeps a copy of the last mode word it loaded. Before a transfer starts, it compares the winner's word with that copy. If the words differ, or if nothing has been loaded since reset, it first sends a load-mode command with the mode word on the write-data bus. It waits for the controller to acknowledge that command, then issues the read or write.

Controller acknowledges and read data go only to the requester that holds the grant. Each requester also sees a flag that is high while the loaded mode equals its own mode word.

Top module: `memArbiter`

## Requirements
- R1: While reset is high and in the cycle after it, no command strobe is driven, the address is zero, every port acknowledge is low and every mode-match flag is low. The loaded-mode copy is invalid after reset.
- R2: In the idle state, the requester with the highest index among those with a miss wins. When all four miss together, they are served in the order 3, 2, 1, 0.
- R3: A grant is held until the granted requester raises its complete input. A miss that arrives during a service does not preempt it and is arbitrated only after the arbiter returns to idle.
- R4: A load-mode command comes before a transfer exactly when the loaded-mode copy is invalid or differs in any of its 32 bits from the winner's mode word. A read or write is only ever issued while the loaded mode matches some requester's word. Mode word layout: the low 3 bits select the burst length (0=1, 1=2, 2=4, 3=8 words) and the upper 29 bits hold the constant 4.
- R5: The load-mode strobe stays high until the controller acknowledges it. It is never high together with read or write. While it is high, the write-data bus carries the winner's mode word.
- R6: During a transfer, the read strobe, address and byte enables come from the granted requester. The write strobe and write data come from that requester too, but write is asserted only while its data-ready input is high.
- R7: A controller acknowledge during a transfer reaches only the granted port. Acknowledges during load-mode reach no port, so at most one port acknowledge is ever high.
- R8: During a transfer, the granted port's read-data output equals the controller's read data and every other port's read-data output is zero.
- R9: The mode-match flag of port i is high exactly when the loaded-mode copy is valid and equal to port i's mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqMiss | input | 4 | Per-requester miss (service request) |
| reqRead | input | 4 | Per-requester read request |
| reqWrite | input | 4 | Per-requester write request |
| reqDataReady | input | 4 | Per-requester write data valid |
| reqComplete | input | 4 | Per-requester end of transaction |
| reqSel | input | 16 | Byte enables, 4 bits per requester |
| reqAddr | input | 128 | Address, 32 bits per requester |
| reqWData | input | 128 | Write data, 32 bits per requester |
| reqMode | input | 128 | Mode word, 32 bits per requester |
| portAck | output | 4 | Per-requester acknowledge |
| portRData | output | 128 | Read data, 32 bits per requester |
| portModeSame | output | 4 | Per-requester loaded-mode match flag |
| ctlLoadMode | output | 1 | Load-mode command to controller |
| ctlRead | output | 1 | Read command to controller |
| ctlWrite | output | 1 | Write command to controller |
| ctlSel | output | 4 | Byte enables to controller |
| ctlAddr | output | 32 | Address to controller |
| ctlWData | output | 32 | Write data or mode word to controller |
| ctlRData | input | 32 | Read data from controller |
| ctlAck | input | 1 | Acknowledge from controller |

## Verification
The bench sweeps every non-empty set of simultaneous misses against several mixes of burst lengths. It checks the order of service against a descending-index model and the presence of each load-mode against a model of the last loaded word. An arbiter that skips the reload would show a missing load-mode on a burst-length change, and one that always reloads would show a spurious load-mode on a repeated mode. A directed case raises higher-priority misses while port 0 is being served: a design that re-arbitrates mid-service would hand port 3 the controller early and break the order 0, 3, 1. A write with data-ready held low must not reach the controller, and on every acknowledge the bench checks address, byte enables, write data and read-data routing, so a mux on the wrong index or an acknowledge broadcast to all ports is exposed.

// File: rtl/memArbPkg.sv
package memArbPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_XFER = 2'd2
  } arbState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic issueLoad;   // drive the load-mode command
    logic issueXfer;   // drive the granted requester's transfer
    logic commitMode;  // copy the winner's mode word into the loaded-mode register
  } arbStrobe_t;

endpackage

// File: rtl/memArbCtrl.sv
module memArbCtrl
  import memArbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] reqMiss,
  input  logic [NUM_PORTS-1:0] reqComplete,
  input  logic [NUM_PORTS-1:0] modeSame,
  input  logic                 ctlAck,
  output arbStrobe_t           strobe,
  output logic [IDX_W-1:0]     grantIdx
);

  arbState_t        state;
  logic [IDX_W-1:0] grantQ;
  logic [IDX_W-1:0] winIdx;
  logic             anyMiss;

  // fixed priority: the highest index with a miss wins
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (reqMiss[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyMiss = |reqMiss;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      grantQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (anyMiss) begin
            grantQ <= winIdx;
            state  <= modeSame[winIdx] ? ST_XFER : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (ctlAck) state <= ST_XFER;
        end
        ST_XFER: begin
          if (reqComplete[grantQ]) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.issueLoad  = (state == ST_LOAD);
    strobe.issueXfer  = (state == ST_XFER);
    strobe.commitMode = (state == ST_LOAD) && ctlAck;
  end

  assign grantIdx = grantQ;

endmodule

// File: rtl/memArbDatapath.sv
module memArbDatapath
  import memArbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter int MODE_W    = 32,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  arbStrobe_t                  strobe,
  input  logic [IDX_W-1:0]            grantIdx,
  input  logic [NUM_PORTS-1:0]        reqRead,
  input  logic [NUM_PORTS-1:0]        reqWrite,
  input  logic [NUM_PORTS-1:0]        reqDataReady,
  input  logic [NUM_PORTS*SEL_W-1:0]  reqSel,
  input  logic [NUM_PORTS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_PORTS*DATA_W-1:0] reqWData,
  input  logic [NUM_PORTS*MODE_W-1:0] reqMode,
  input  logic [DATA_W-1:0]           ctlRData,
  input  logic                        ctlAck,
  output logic                        ctlLoadMode,
  output logic                        ctlRead,
  output logic                        ctlWrite,
  output logic [SEL_W-1:0]            ctlSel,
  output logic [ADDR_W-1:0]           ctlAddr,
  output logic [DATA_W-1:0]           ctlWData,
  output logic [NUM_PORTS-1:0]        portAck,
  output logic [NUM_PORTS*DATA_W-1:0] portRData,
  output logic [NUM_PORTS-1:0]        portModeSame
);

  logic [SEL_W-1:0]  selArr   [NUM_PORTS];
  logic [ADDR_W-1:0] addrArr  [NUM_PORTS];
  logic [DATA_W-1:0] wdataArr [NUM_PORTS];
  logic [MODE_W-1:0] modeArr  [NUM_PORTS];

  logic [MODE_W-1:0] loadedMode;
  logic              modeValid;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : gPort
    assign selArr[i]   = reqSel[i*SEL_W +: SEL_W];
    assign addrArr[i]  = reqAddr[i*ADDR_W +: ADDR_W];
    assign wdataArr[i] = reqWData[i*DATA_W +: DATA_W];
    assign modeArr[i]  = reqMode[i*MODE_W +: MODE_W];

    assign portModeSame[i] = modeValid && (modeArr[i] == loadedMode);

    logic isGrant;
    assign isGrant = strobe.issueXfer && (grantIdx == IDX_W'(i));
    assign portAck[i] = isGrant && ctlAck;
    assign portRData[i*DATA_W +: DATA_W] = isGrant ? ctlRData : '0;
  end

  // copy of the mode word held by the controller
  always_ff @(posedge clk) begin
    if (rst) begin
      loadedMode <= '0;
      modeValid  <= 1'b0;
    end else if (strobe.commitMode) begin
      loadedMode <= modeArr[grantIdx];
      modeValid  <= 1'b1;
    end
  end

  logic active;
  assign active = strobe.issueLoad || strobe.issueXfer;

  always_comb begin
    ctlLoadMode = strobe.issueLoad;
    ctlRead     = strobe.issueXfer && reqRead[grantIdx];
    ctlWrite    = strobe.issueXfer && reqWrite[grantIdx] && reqDataReady[grantIdx];
    ctlAddr     = active ? addrArr[grantIdx] : '0;
    ctlSel      = strobe.issueXfer ? selArr[grantIdx] : '0;
    if (strobe.issueLoad)      ctlWData = DATA_W'(modeArr[grantIdx]);
    else if (strobe.issueXfer) ctlWData = wdataArr[grantIdx];
    else                       ctlWData = '0;
  end

endmodule

// File: rtl/memArbiter.sv
module memArbiter
  import memArbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 4,
  parameter int MODE_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PORTS-1:0]        reqMiss,
  input  logic [NUM_PORTS-1:0]        reqRead,
  input  logic [NUM_PORTS-1:0]        reqWrite,
  input  logic [NUM_PORTS-1:0]        reqDataReady,
  input  logic [NUM_PORTS-1:0]        reqComplete,
  input  logic [NUM_PORTS*SEL_W-1:0]  reqSel,
  input  logic [NUM_PORTS*ADDR_W-1:0] reqAddr,
  input  logic [NUM_PORTS*DATA_W-1:0] reqWData,
  input  logic [NUM_PORTS*MODE_W-1:0] reqMode,
  output logic [NUM_PORTS-1:0]        portAck,
  output logic [NUM_PORTS*DATA_W-1:0] portRData,
  output logic [NUM_PORTS-1:0]        portModeSame,
  output logic                        ctlLoadMode,
  output logic                        ctlRead,
  output logic                        ctlWrite,
  output logic [SEL_W-1:0]            ctlSel,
  output logic [ADDR_W-1:0]           ctlAddr,
  output logic [DATA_W-1:0]           ctlWData,
  input  logic [DATA_W-1:0]           ctlRData,
  input  logic                        ctlAck
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  arbStrobe_t       strobe;
  logic [IDX_W-1:0] grantIdx;

  memArbCtrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqMiss    (reqMiss),
    .reqComplete(reqComplete),
    .modeSame   (portModeSame),
    .ctlAck     (ctlAck),
    .strobe     (strobe),
    .grantIdx   (grantIdx)
  );

  memArbDatapath #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W),
    .MODE_W   (MODE_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .grantIdx    (grantIdx),
    .reqRead     (reqRead),
    .reqWrite    (reqWrite),
    .reqDataReady(reqDataReady),
    .reqSel      (reqSel),
    .reqAddr     (reqAddr),
    .reqWData    (reqWData),
    .reqMode     (reqMode),
    .ctlRData    (ctlRData),
    .ctlAck      (ctlAck),
    .ctlLoadMode (ctlLoadMode),
    .ctlRead     (ctlRead),
    .ctlWrite    (ctlWrite),
    .ctlSel      (ctlSel),
    .ctlAddr     (ctlAddr),
    .ctlWData    (ctlWData),
    .portAck     (portAck),
    .portRData   (portRData),
    .portModeSame(portModeSame)
  );

endmodule

// File: rtl/memArbiterChk.sv
module memArbiterChk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ctlLoadMode,
  input logic                 ctlRead,
  input logic                 ctlWrite,
  input logic                 ctlAck,
  input logic [NUM_PORTS-1:0] portAck,
  input logic [NUM_PORTS-1:0] portModeSame
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!ctlLoadMode && !ctlRead && !ctlWrite && portAck == '0 && portModeSame == '0));

  // R5
  loadmode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctlLoadMode && !ctlAck) |=> ctlLoadMode);

  // R5
  load_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ctlLoadMode |-> !(ctlRead || ctlWrite));

  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(portAck));

  // R7
  ack_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|portAck) |-> ctlAck);

  // R9
  mode_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ctlLoadMode && ctlAck) |=> (|portModeSame));

  // R4
  xfer_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ctlRead || ctlWrite) |-> (|portModeSame));

endmodule

bind memArbiter memArbiterChk #(.NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/memArbiter_tb.sv
`timescale 1ns/1ps
module memArbiter_tb;
  localparam int N = 4, AW = 32, DW = 32, SW = 4, MW = 32, LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]    reqMiss, reqRead, reqWrite, reqDataReady, reqComplete;
  logic [N*SW-1:0] reqSel;
  logic [N*AW-1:0] reqAddr;
  logic [N*DW-1:0] reqWData;
  logic [N*MW-1:0] reqMode;
  logic [N-1:0]    portAck, portModeSame;
  logic [N*DW-1:0] portRData;
  logic            ctlLoadMode, ctlRead, ctlWrite, ctlAck;
  logic [SW-1:0]   ctlSel;
  logic [AW-1:0]   ctlAddr;
  logic [DW-1:0]   ctlWData, ctlRData;

  memArbiter #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .MODE_W(MW)) u_dut (.*);

  int nChecks = 0, nBad = 0;
  bit timedOut = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // requester models: miss is pending while request count != done count
  logic [7:0] reqGen [N];
  logic [7:0] doneGen[N];
  logic [7:0] ackCnt [N];
  logic [7:0] burst  [N];

  for (genvar g = 0; g < N; g++) begin : gReq
    assign reqMiss[g]     = (reqGen[g] != doneGen[g]);
    assign burst[g]       = 8'd1 << reqMode[g*MW +: 3];
    assign reqComplete[g] = reqMiss[g] && (ackCnt[g] == burst[g]);
  end

  logic [3:0] latCnt;
  wire cmdOn = ctlLoadMode || ctlRead || ctlWrite;

  // controller model: one acknowledge after LAT cycles of an active command
  always @(posedge clk) begin
    if (rst) begin
      ctlAck <= 1'b0; latCnt <= '0; ctlRData <= 32'h5A5A_0001;
      for (int i = 0; i < N; i++) begin doneGen[i] <= '0; ackCnt[i] <= '0; end
    end else begin
      if (!cmdOn || ctlAck) begin
        ctlAck <= 1'b0; latCnt <= '0;
      end else if (latCnt == 4'(LAT - 1)) begin
        ctlAck <= 1'b1; ctlRData <= ctlRData + 32'h0103_0507;
      end else begin
        latCnt <= latCnt + 4'd1;
      end
      for (int i = 0; i < N; i++) begin
        if (reqComplete[i]) begin doneGen[i] <= doneGen[i] + 8'd1; ackCnt[i] <= '0; end
        else if (portAck[i]) ackCnt[i] <= ackCnt[i] + 8'd1;
      end
    end
  end

  // event recording and per-acknowledge checks
  int        orderList[N];
  int        orderLen;
  bit        pendingLoad;
  bit        loadFlag[N];
  logic [31:0] loadWord, loadWordAt[N];

  always @(negedge clk) begin
    if (!rst) begin
      if (ctlLoadMode && ctlAck) begin pendingLoad = 1; loadWord = ctlWData; end
      for (int i = 0; i < N; i++) begin
        if (portAck[i]) begin
          if (ackCnt[i] == 0) begin
            if (orderLen < N) orderList[orderLen] = i;
            orderLen++;
            loadFlag[i] = pendingLoad; loadWordAt[i] = loadWord; pendingLoad = 0;
          end
          // R6 address, byte enables and write data of the granted requester
          check(ctlAddr == reqAddr[i*AW +: AW], "R6 addr", ctlAddr, reqAddr[i*AW +: AW]);
          check(ctlSel == reqSel[i*SW +: SW], "R6 sel", 32'(ctlSel), 32'(reqSel[i*SW +: SW]));
          if (ctlWrite)
            check(ctlWData == reqWData[i*DW +: DW], "R6 wdata", ctlWData, reqWData[i*DW +: DW]);
          // R8 read data routing
          for (int j = 0; j < N; j++) begin
            if (j == i) check(portRData[j*DW +: DW] == ctlRData, "R8 granted rdata", portRData[j*DW +: DW], ctlRData);
            else        check(portRData[j*DW +: DW] == '0, "R8 idle rdata", portRData[j*DW +: DW], 32'h0);
          end
          // R7 only one port sees the acknowledge
          check($countones(portAck) == 1, "R7 ack isolation", 32'(portAck), 32'h1 << i);
        end
      end
    end
  end

  // reference model of the controller's loaded mode
  bit          mValid = 0;
  logic [31:0] mLast  = '0;
  int          runId  = 0;

  function automatic logic [31:0] modeWord(input int code);
    return {29'h4, 3'(code)};
  endfunction

  task automatic setPort(input int p, input int code, input bit rd, input bit rdy);
    logic [31:0] a;
    a = 32'h1000_0000 + 32'(runId << 4) + 32'(p * 4);
    reqMode[p*MW +: MW]  = modeWord(code);
    reqAddr[p*AW +: AW]  = a;
    reqWData[p*DW +: DW] = ~a;
    reqSel[p*SW +: SW]   = 4'hF ^ 4'(p);
    reqRead[p]           = rd;
    reqWrite[p]          = !rd;
    reqDataReady[p]      = rdy;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (reqMiss != '0 && !timedOut) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic verify(input int expOrd[N], input int expCnt, input string tag);
    check(orderLen == expCnt, {tag, " grant count"}, 32'(orderLen), 32'(expCnt));
    for (int k = 0; k < expCnt; k++) begin
      int p;
      bit expLoad;
      p = expOrd[k];
      check(orderList[k] == p, {tag, " grant order"}, 32'(orderList[k]), 32'(p));
      expLoad = !mValid || (reqMode[p*MW +: MW] != mLast);
      // R4 load-mode inserted exactly on a change
      check(loadFlag[p] == expLoad, "R4 load-mode insertion", 32'(loadFlag[p]), 32'(expLoad));
      // R5 mode word presented on the write-data bus
      if (expLoad) check(loadWordAt[p] == reqMode[p*MW +: MW], "R5 load word", loadWordAt[p], reqMode[p*MW +: MW]);
      mLast = reqMode[p*MW +: MW]; mValid = 1;
    end
    // R9 per-port match flags
    for (int i = 0; i < N; i++)
      check(portModeSame[i] == (mValid && reqMode[i*MW +: MW] == mLast), "R9 mode match",
            32'(portModeSame[i]), 32'(mValid && reqMode[i*MW +: MW] == mLast));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timedOut = 1;
  end

  initial begin
    reqSel = '0; reqAddr = '0; reqWData = '0; reqMode = '0;
    reqRead = '0; reqWrite = '0; reqDataReady = '0;
    orderLen = 0; pendingLoad = 0; loadWord = '0;
    for (int i = 0; i < N; i++) begin reqGen[i] = '0; loadFlag[i] = 0; loadWordAt[i] = '0; orderList[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!ctlLoadMode && !ctlRead && !ctlWrite, "R1 no command in reset", 32'({ctlLoadMode, ctlRead, ctlWrite}), 32'h0);
    check(portAck == '0 && portModeSame == '0, "R1 port outputs in reset", 32'({portAck, portModeSame}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(ctlAddr == '0 && !ctlLoadMode, "R1 idle after reset", ctlAddr, 32'h0);
    check(portModeSame == '0, "R1 loaded mode invalid", 32'(portModeSame), 32'h0);

    // R2 sweep: every miss set with several burst-length mixes, all raised together
    for (int pat = 0; pat < 4; pat++) begin
      for (int mask = 1; mask < 16; mask++) begin
        int expOrd[N];
        int cnt;
        @(negedge clk);
        runId++;
        for (int p = 0; p < N; p++) setPort(p, (pat == 3) ? 1 : (p + pat) % 4, ((p + pat) % 2) == 1, 1'b1);
        orderLen = 0;
        for (int p = 0; p < N; p++) if (mask[p]) reqGen[p] = reqGen[p] + 8'd1;
        waitIdle();
        cnt = 0;
        for (int p = N - 1; p >= 0; p--) if (mask[p]) begin expOrd[cnt] = p; cnt++; end
        verify(expOrd, cnt, "R2");
      end
    end

    // R3 late higher-priority misses do not preempt the current grant
    begin
      int expOrd[N];
      @(negedge clk);
      runId++;
      for (int p = 0; p < N; p++) setPort(p, p % 4, 1'b1, 1'b1);
      orderLen = 0;
      reqGen[0] = reqGen[0] + 8'd1;
      while (!portAck[0] && !timedOut) @(negedge clk);
      reqGen[3] = reqGen[3] + 8'd1;
      reqGen[1] = reqGen[1] + 8'd1;
      waitIdle();
      expOrd[0] = 0; expOrd[1] = 3; expOrd[2] = 1; expOrd[3] = 0;
      verify(expOrd, 3, "R3");
    end

    // R6 write held back while data-ready is low
    begin
      int expOrd[N];
      bit early;
      @(negedge clk);
      runId++;
      setPort(2, 2, 1'b0, 1'b0);
      orderLen = 0;
      reqGen[2] = reqGen[2] + 8'd1;
      early = 0;
      repeat (15) begin
        @(negedge clk);
        if (ctlWrite || portAck != '0) early = 1;
      end
      check(!early, "R6 write waits for data-ready", 32'(early), 32'h0);
      reqDataReady[2] = 1'b1;
      waitIdle();
      expOrd[0] = 2; expOrd[1] = 0; expOrd[2] = 0; expOrd[3] = 0;
      verify(expOrd, 1, "R6");
    end

    if (timedOut) begin
      nChecks++; nBad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    end
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule